// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block drives the two active-low host strobes of a parallel ATA bus, read and write, for programmed I/O and multiword DMA cycles. A request names the direction, whether the access targets a task-file register or moves data, and how many cycles the burst holds. Every phase length comes from one 32-bit timing word. The word supplies separate setup, active and recovery counts for task-file accesses and for data bursts. Each phase lasts its field value plus one clock.

On acceptance the block latches the timing word and the request. It holds both strobes high for the first-cycle setup delay. It then alternates a low phase and a high recovery phase once per cycle of the burst. After the last recovery it pulses `done` and drops `busy`. The three mode bits of the word are latched with the request and brought out as flags for the surrounding transfer logic.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: After a clock with `rst` high, `busy` and `done` are 0, `rd_n` and `wr_n` are 1, and the flags `dma_mode`, `bus_master` and `fifo_on` are 0.
- R2: A request with `req_valid` high is accepted only at the end of a clock in which `busy` is low. A request presented while `busy` is high has no effect on the waveform or the flags.
- R3: In the clock after acceptance, `busy` rises and both strobes stay high for P+1 clocks. P is bits 24:22 of the timing word for a data burst and bits 27:25 for a task-file access.
- R4: Each cycle holds the selected strobe low for A+1 clocks. A is bits 8:4 for a data burst and bits 17:13 for a task-file access.
- R5: Each low phase, including the last one, is followed by R+1 clocks with both strobes high. R is bits 3:0 for a data burst and bits 12:9 for a task-file access.
- R6: A data burst with `req_len` = N > 0 gives exactly N low pulses, and `req_len` = 0 gives one pulse. A task-file access always gives one pulse, whatever `req_len` holds.
- R7: `req_write` = 1 selects `wr_n` and `req_write` = 0 selects `rd_n`. The other strobe stays high, so the two are never low together.
- R8: In the clock after the last recovery phase, `done` is 1 for exactly one clock and `busy` is 0. A request presented in that clock is accepted at its end.
- R9: The timing word is sampled only at acceptance. Changing `cfg_word` during a burst does not alter that burst's phase lengths.
- R10: At acceptance, `dma_mode` takes bit 29 and `bus_master` takes bit 30. `fifo_on` takes bit 31 only when bit 29 is 0, because the FIFO applies to PIO alone. The flags hold until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_taskfile | input | 1 | 1 = task-file register access, 0 = data burst |
| req_len | input | LEN_W | Data burst cycle count (0 treated as 1) |
| cfg_word | input | 32 | Packed timing and mode word |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-clock completion pulse |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| dma_mode | output | 1 | Latched DMA enable |
| bus_master | output | 1 | Latched PIO bus-master select |
| fifo_on | output | 1 | Latched FIFO enable, PIO only |

## Verification
A phase counter loaded from the wrong field, or loaded off by one, moves the next strobe edge by at least one clock. A cycle-accurate comparison therefore catches it at the first edge of the affected phase. A burst counter that is wrong shows up after the last recovery phase, as an extra low pulse or a `done` that comes early. A sequencer state that is wrong leaves a strobe low while idle, or lets `busy` stay high past completion, within one clock. A flag or timing word that is not held would alter the strobes or flags mid-burst as soon as `cfg_word` changes.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

  localparam int CFG_W   = 32;
  localparam int ACT_W   = 5;
  localparam int REC_W   = 4;
  localparam int PRE_W   = 3;
  localparam int PH_W    = ACT_W;

  localparam int DMA_BIT  = 29;
  localparam int MST_BIT  = 30;
  localparam int FIFO_BIT = 31;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [ACT_W-1:0] act;
    logic [REC_W-1:0] rec;
  } phase_times_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_REC
  } seq_state_t;

  // Select the field set that matches the access class.
  function automatic phase_times_t pick_times(input logic [CFG_W-1:0] w,
                                              input logic tf);
    phase_times_t t;
    if (tf) begin
      t.pre = w[27:25];
      t.act = w[17:13];
      t.rec = w[12:9];
    end else begin
      t.pre = w[24:22];
      t.act = w[8:4];
      t.rec = w[3:0];
    end
    return t;
  endfunction

endpackage

// File: rtl/ata_down_counter.sv
module ata_down_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         zero
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec && (count != '0)) begin
      count <= count - 1'b1;
    end
  end

  assign zero = (count == '0);

endmodule

// File: rtl/ata_cfg_latch.sv
module ata_cfg_latch
  import ata_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic             tf_in,
  input  logic             wr_in,
  output phase_times_t     times,
  output logic             wr_sel,
  output logic             dma_mode,
  output logic             bus_master,
  output logic             fifo_on
);

  phase_times_t sel_times;
  assign sel_times = pick_times(cfg_in, tf_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      times      <= '0;
      wr_sel     <= 1'b0;
      dma_mode   <= 1'b0;
      bus_master <= 1'b0;
      fifo_on    <= 1'b0;
    end else if (capture) begin
      times      <= sel_times;
      wr_sel     <= wr_in;
      dma_mode   <= cfg_in[DMA_BIT];
      bus_master <= cfg_in[MST_BIT];
      fifo_on    <= cfg_in[FIFO_BIT] & ~cfg_in[DMA_BIT];
    end
  end

endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
  import ata_strobe_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_taskfile,
  input  logic [LEN_W-1:0] req_len,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             busy,
  output logic             done,
  output logic             rd_n,
  output logic             wr_n,
  output logic             dma_mode,
  output logic             bus_master,
  output logic             fifo_on
);

  seq_state_t   st, nst;
  phase_times_t t_new, t_held;
  logic         accept;
  logic         wr_sel;
  logic         last;

  logic             ph_load, ph_dec, ph_zero;
  logic [PH_W-1:0]  ph_val, ph_count;
  logic             bc_load, bc_dec, bc_zero;
  logic [LEN_W-1:0] bc_val, bc_count;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_word[21:18], cfg_word[28], ph_count, bc_count};

  assign accept = (st == ST_IDLE) && req_valid;
  assign t_new  = pick_times(cfg_word, req_taskfile);

  ata_cfg_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .capture    (accept),
    .cfg_in     (cfg_word),
    .tf_in      (req_taskfile),
    .wr_in      (req_write),
    .times      (t_held),
    .wr_sel     (wr_sel),
    .dma_mode   (dma_mode),
    .bus_master (bus_master),
    .fifo_on    (fifo_on)
  );

  ata_down_counter #(.W(PH_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .dec      (ph_dec),
    .load_val (ph_val),
    .count    (ph_count),
    .zero     (ph_zero)
  );

  ata_down_counter #(.W(LEN_W)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .load     (bc_load),
    .dec      (bc_dec),
    .load_val (bc_val),
    .count    (bc_count),
    .zero     (bc_zero)
  );

  // Remaining cycles after the first: task-file and zero length give none.
  always_comb begin
    if (req_taskfile || (req_len == '0)) bc_val = '0;
    else                                 bc_val = req_len - 1'b1;
  end

  always_comb begin
    nst     = st;
    ph_load = 1'b0;
    ph_dec  = 1'b0;
    ph_val  = '0;
    bc_load = 1'b0;
    bc_dec  = 1'b0;
    last    = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          nst     = ST_SETUP;
          ph_load = 1'b1;
          ph_val  = PH_W'(t_new.pre);
          bc_load = 1'b1;
        end
      end
      ST_SETUP: begin
        if (ph_zero) begin
          nst     = ST_ACT;
          ph_load = 1'b1;
          ph_val  = PH_W'(t_held.act);
        end else begin
          ph_dec = 1'b1;
        end
      end
      ST_ACT: begin
        if (ph_zero) begin
          nst     = ST_REC;
          ph_load = 1'b1;
          ph_val  = PH_W'(t_held.rec);
        end else begin
          ph_dec = 1'b1;
        end
      end
      ST_REC: begin
        if (ph_zero) begin
          if (bc_zero) begin
            nst  = ST_IDLE;
            last = 1'b1;
          end else begin
            nst     = ST_ACT;
            ph_load = 1'b1;
            ph_val  = PH_W'(t_held.act);
            bc_dec  = 1'b1;
          end
        end else begin
          ph_dec = 1'b1;
        end
      end
      default: nst = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
      rd_n <= 1'b1;
      wr_n <= 1'b1;
    end else begin
      st   <= nst;
      busy <= (nst != ST_IDLE);
      done <= last;
      rd_n <= !((nst == ST_ACT) && !wr_sel);
      wr_n <= !((nst == ST_ACT) && wr_sel);
    end
  end

endmodule

// File: rtl/ata_pio_strobe_chk.sv
module ata_pio_strobe_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic rd_n,
  input logic wr_n,
  input logic dma_mode,
  input logic bus_master,
  input logic fifo_on
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R7

  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (rd_n && wr_n)); // R7

  AST_SETUP_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (rd_n && wr_n)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R8

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable({dma_mode, bus_master, fifo_on})); // R10

  AST_FIFO_PIO_ONLY: assert property (@(posedge clk) disable iff (rst)
    fifo_on |-> !dma_mode); // R10

endmodule

bind ata_pio_strobe_gen ata_pio_strobe_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .dma_mode   (dma_mode),
  .bus_master (bus_master),
  .fifo_on    (fifo_on)
);

// File: tb/sim_ata_pio_strobe_gen.sv
module sim_ata_pio_strobe_gen;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             req_valid, req_write, req_taskfile;
  logic [LEN_W-1:0] req_len;
  logic [31:0]      cfg_word;
  logic busy, done, rd_n, wr_n, dma_mode, bus_master, fifo_on;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_pio_strobe_gen #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_taskfile(req_taskfile), .req_len(req_len), .cfg_word(cfg_word),
    .busy(busy), .done(done), .rd_n(rd_n), .wr_n(wr_n),
    .dma_mode(dma_mode), .bus_master(bus_master), .fifo_on(fifo_on)
  );

  typedef struct packed {
    logic       busy;
    logic       done;
    logic       rd_n;
    logic       wr_n;
    logic [2:0] tag;
  } exp_t;

  exp_t  q[$];
  exp_t  e;
  logic  cur_busy;
  logic  m_dma, m_mst, m_fifo;
  int    exp_pulses, pulses;
  logic  prev_high = 1'b1;
  int    n_checks = 0, n_err = 0;
  string extra_tag = "";

  function automatic string tagname(input logic [2:0] t);
    case (t)
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R5";
      3'd4:    return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string what, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int pd, input int ad, input int rd,
                                         input int pt, input int at, input int rt,
                                         input bit dma, input bit mst, input bit ff);
    logic [31:0] w;
    w        = '0;
    w[3:0]   = rd[3:0];
    w[8:4]   = ad[4:0];
    w[12:9]  = rt[3:0];
    w[17:13] = at[4:0];
    w[21:18] = 4'ha;
    w[24:22] = pd[2:0];
    w[27:25] = pt[2:0];
    w[28]    = 1'b1;
    w[29]    = dma;
    w[30]    = mst;
    w[31]    = ff;
    return w;
  endfunction

  task automatic push(input logic b, input logic d, input logic r, input logic w,
                      input logic [2:0] t);
    exp_t x;
    x.busy = b; x.done = d; x.rd_n = r; x.wr_n = w; x.tag = t;
    q.push_back(x);
  endtask

  task automatic model_accept();
    int pre, act, rec, n;
    if (req_taskfile) begin
      pre = int'(cfg_word[27:25]); act = int'(cfg_word[17:13]); rec = int'(cfg_word[12:9]);
      n = 1;
    end else begin
      pre = int'(cfg_word[24:22]); act = int'(cfg_word[8:4]); rec = int'(cfg_word[3:0]);
      n = (req_len == 0) ? 1 : int'(req_len);
    end
    exp_pulses = n;
    m_dma  = cfg_word[29];
    m_mst  = cfg_word[30];
    m_fifo = cfg_word[31] & ~cfg_word[29];
    for (int i = 0; i <= pre; i++) push(1'b1, 1'b0, 1'b1, 1'b1, 3'd1);
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i <= act; i++) push(1'b1, 1'b0, req_write, !req_write, 3'd2);
      for (int i = 0; i <= rec; i++) push(1'b1, 1'b0, 1'b1, 1'b1, 3'd3);
    end
    push(1'b0, 1'b1, 1'b1, 1'b1, 3'd4);
  endtask

  // Reference model: advances one entry per clock.
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_dma = 1'b0; m_mst = 1'b0; m_fifo = 1'b0;
    end else begin
      cur_busy = (q.size() > 0) ? q[0].busy : 1'b0;
      if (q.size() > 0) void'(q.pop_front());
      if (!cur_busy && req_valid) model_accept();
    end
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0) e = q[0];
      else begin e.busy = 0; e.done = 0; e.rd_n = 1; e.wr_n = 1; e.tag = 0; end
      chk("busy", {tagname(e.tag), extra_tag}, 32'(busy), 32'(e.busy));
      chk("done", {tagname(e.tag), extra_tag}, 32'(done), 32'(e.done));
      chk("rd_n", {tagname(e.tag), "/R7", extra_tag}, 32'(rd_n), 32'(e.rd_n));
      chk("wr_n", {tagname(e.tag), "/R7", extra_tag}, 32'(wr_n), 32'(e.wr_n));
      chk("flags", "R10", {29'd0, dma_mode, bus_master, fifo_on}, {29'd0, m_dma, m_mst, m_fifo});
      if (prev_high && !(rd_n && wr_n)) pulses++;
      prev_high = rd_n && wr_n;
      if (done) begin
        chk("pulse count", "R6", pulses, exp_pulses);
        pulses = 0;
      end
    end
  end

  task automatic drive_now(input logic w, input logic tf, input int len, input logic [31:0] c);
    req_valid = 1'b1; req_write = w; req_taskfile = tf; req_len = len[LEN_W-1:0]; cfg_word = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic issue(input logic w, input logic tf, input int len, input logic [31:0] c);
    @(negedge clk);
    drive_now(w, tf, len, c);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    pulses = 0; exp_pulses = 0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_taskfile = 1'b0;
    req_len = '0; cfg_word = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("reset outputs", "R1",
        {25'd0, busy, done, rd_n, wr_n, dma_mode, bus_master, fifo_on}, 32'b0011000);

    // R3 R4 R5 R6: data read burst of three
    issue(1'b0, 1'b0, 3, mk_cfg(2, 3, 1, 5, 7, 4, 0, 0, 0));
    wait_idle();
    // R7: data write burst, DMA set so FIFO flag masked (R10)
    issue(1'b1, 1'b0, 2, mk_cfg(1, 2, 3, 0, 0, 0, 1, 0, 1));
    wait_idle();
    // R6: task-file read ignores length
    issue(1'b0, 1'b1, 5, mk_cfg(6, 1, 1, 3, 4, 2, 0, 1, 1));
    wait_idle();
    // task-file write
    issue(1'b1, 1'b1, 1, mk_cfg(0, 0, 0, 7, 9, 11, 1, 1, 0));
    wait_idle();
    // R6: zero length treated as one
    issue(1'b0, 1'b0, 0, mk_cfg(1, 1, 1, 0, 0, 0, 0, 0, 0));
    wait_idle();
    // minimum timings
    issue(1'b1, 1'b0, 4, mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0));
    wait_idle();
    // maximum timings
    issue(1'b0, 1'b0, 2, mk_cfg(7, 31, 15, 7, 31, 15, 0, 1, 1));
    wait_idle();
    // R8: back-to-back request presented in the done clock
    issue(1'b0, 1'b0, 2, mk_cfg(1, 2, 1, 0, 0, 0, 0, 0, 0));
    do @(negedge clk); while (q.size() != 1);
    drive_now(1'b1, 1'b1, 1, mk_cfg(0, 0, 0, 2, 3, 2, 1, 0, 0));
    wait_idle();
    // R2: request while busy is ignored
    issue(1'b0, 1'b0, 3, mk_cfg(2, 4, 2, 0, 0, 0, 0, 0, 0));
    repeat (5) @(negedge clk);
    drive_now(1'b1, 1'b1, 1, mk_cfg(0, 0, 0, 0, 0, 0, 1, 1, 1));
    wait_idle();
    // R9: timing word changed mid-burst
    issue(1'b1, 1'b0, 3, mk_cfg(3, 5, 2, 1, 1, 1, 0, 1, 0));
    extra_tag = "/R9";
    repeat (4) @(negedge clk);
    cfg_word = mk_cfg(0, 0, 0, 0, 0, 0, 1, 0, 1);
    repeat (12) @(negedge clk);
    cfg_word = mk_cfg(7, 31, 15, 7, 31, 15, 0, 0, 1);
    wait_idle();
    extra_tag = "";

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule